// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Overlap Correction

This block is the digital back end of a 12-bit pipelined analog-to-digital converter. The converter has four front stages that each deliver a 3-bit raw code and a last 4-bit flash stage. Only two of each front stage's three bits are effective. The third bit gives redundancy, so a later stage can make up for a wrong decision in an earlier one. A sample moves through the analog stages one stage per clock. Its codes therefore reach this block in five consecutive cycles, and the block takes a new sample every cycle.

Each stage code passes through its own shift register, sized so that all five codes of one sample leave their registers together. The aligned codes are added with a 2-bit step between adjacent front stages, so neighbouring stages overlap by one bit. A fixed centring offset is then removed and the sum is clamped to twelve bits. The result is registered and marked with an output-valid pulse. Between valid results the output code holds its last value.

Top module: `pipe_adc_backend`

## Requirements
- R1: The block accepts one sample per clock. Back-to-back samples produce back-to-back results in the same order, and out_valid rises exactly once per sample.
- R2: A sample's stage-1 code and in_valid are sampled at clock edge n. Stage k (k = 2..4) occupies stg_codes bits [3k-1:3k-3] and is sampled at edge n+k-1. The final code is sampled at edge n+4. The result and out_valid appear after edge n+5.
- R3: Before clamping, the result is 1024*c1 + 256*c2 + 64*c3 + 16*c4 + f - 2720. Here c1 is stg_codes[2:0], c4 is stg_codes[11:9] and f is fin_code.
- R4: If a front stage's code is one count high and the next stage's code is four counts lower, the result is the same as for the ideal codes.
- R5: A pre-clamp value above 4095 gives out_code = 4095. A value of exactly 4095 passes through unchanged.
- R6: A negative pre-clamp value gives out_code = 0. A value of exactly 0 passes through unchanged.
- R7: After reset, out_valid = 0 and out_code = 0. In any cycle without a valid result, out_valid = 0 and out_code keeps its previous value.
- R8: A stage input that changes in cycles where it does not belong to a valid sample has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks a new sample, sent together with its stage-1 code |
| stg_codes | input | 12 | Raw front-stage codes, stage 1 in the low 3 bits |
| fin_code | input | 4 | Raw code of the last flash stage |
| out_valid | output | 1 | One-cycle pulse for each corrected result |
| out_code | output | 12 | Corrected, clamped 12-bit result |

## Verification
A single isolated sample fixes the latency and the stage weights. A continuous stream of eight samples with codes that differ from one sample to the next shows that the alignment keeps samples apart, since a delay line of the wrong depth would mix codes from neighbouring samples. Pairs of samples that carry deliberate one-count decision errors with compensating later codes must give the same value as the ideal codes, which tests the overlap addition. Codes at the extremes, just past the range and exactly at the range limits test the clamping. Sparse samples with noise on the unused input cycles show that the output holds between results and that the unused cycles are ignored.

// File: rtl/adcbe_pkg.sv
package adcbe_pkg;

  // Bit position of front stage i (0 = first stage) in the combined sum.
  function automatic int stage_shift(int i, int nstg, int ebits, int fbits);
    return fbits + ebits * (nstg - 1 - i);
  endfunction

  // Sum of the half-range centring shifts added by the overlap stages.
  function automatic int centre_offset(int nstg, int ebits, int fbits);
    int acc;
    acc = 0;
    for (int i = 0; i < nstg; i++)
      acc += (1 << (ebits - 1)) << stage_shift(i, nstg, ebits, fbits);
    return acc;
  endfunction

endpackage

// File: rtl/adcbe_rst_sync.sv
module adcbe_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/adcbe_delay.sv
module adcbe_delay #(
  parameter int W = 3,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] pipe_q [D];
  logic [W-1:0] pipe_d [D];

  always_comb begin
    pipe_d[0] = din;
    for (int i = 1; i < D; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) pipe_q[i] <= '0;
    end else begin
      for (int i = 0; i < D; i++) pipe_q[i] <= pipe_d[i];
    end
  end

  assign dout = pipe_q[D-1];

endmodule

// File: rtl/adcbe_combine.sv
module adcbe_combine #(
  parameter int NSTG  = 4,
  parameter int SBITS = 3,
  parameter int EBITS = 2,
  parameter int FBITS = 4,
  parameter int OUT_W = NSTG * EBITS + FBITS
) (
  input  logic [NSTG*SBITS-1:0] codes,
  input  logic [FBITS-1:0]      fcode,
  output logic [OUT_W-1:0]      result
);

  localparam int SUM_W  = OUT_W + SBITS + 1;
  localparam int OFFSET = adcbe_pkg::centre_offset(NSTG, EBITS, FBITS);
  localparam int MAXV   = (1 << OUT_W) - 1;
  localparam int NOM_LO = 1 << (EBITS - 1);
  localparam int NOM_HI = NOM_LO + (1 << EBITS) - 1;

  logic [SUM_W-1:0]      acc;
  logic signed [SUM_W:0] diff;
  logic                  clip;
  logic                  nominal;

  always_comb begin
    acc = SUM_W'(fcode);
    for (int i = 0; i < NSTG; i++)
      acc = acc + (SUM_W'(codes[i*SBITS +: SBITS])
                   << adcbe_pkg::stage_shift(i, NSTG, EBITS, FBITS));
    diff = $signed({1'b0, acc}) - $signed((SUM_W+1)'(OFFSET));
    if (diff < 0) begin
      result = '0;
      clip   = 1'b1;
    end else if (diff > $signed((SUM_W+1)'(MAXV))) begin
      result = OUT_W'(MAXV);
      clip   = 1'b1;
    end else begin
      result = diff[OUT_W-1:0];
      clip   = 1'b0;
    end
  end

  // Codes inside the centred window can never leave the output range.
  always_comb begin
    nominal = 1'b1;
    for (int i = 0; i < NSTG; i++)
      if (codes[i*SBITS +: SBITS] < SBITS'(NOM_LO) ||
          codes[i*SBITS +: SBITS] > SBITS'(NOM_HI))
        nominal = 1'b0;
  end

  always_comb begin
    if (nominal) begin
      a_r5_nominal_no_clip: assert (!clip);  // R5, R6: clamp only out of window
    end
  end

endmodule

// File: rtl/pipe_adc_backend.sv
module pipe_adc_backend #(
  parameter int NSTG  = 4,
  parameter int SBITS = 3,
  parameter int EBITS = 2,
  parameter int FBITS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [NSTG*SBITS-1:0]         stg_codes,
  input  logic [FBITS-1:0]              fin_code,
  output logic                          out_valid,
  output logic [NSTG*EBITS+FBITS-1:0]   out_code
);

  localparam int OUT_W = NSTG * EBITS + FBITS;
  localparam int LAT   = NSTG + 2;
  localparam int CNT_W = $clog2(LAT + 2);

  logic                  srst_n;
  logic [NSTG*SBITS-1:0] al_codes;
  logic [FBITS-1:0]      al_fin;
  logic                  vld_al;
  logic [OUT_W-1:0]      sum_res;

  logic                  out_valid_q, out_valid_d;
  logic [OUT_W-1:0]      out_code_q, out_code_d;

  adcbe_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Stage i code arrives i cycles after stage 0; delay so all meet the final code.
  for (genvar g = 0; g < NSTG; g++) begin : g_stage_dly
    adcbe_delay #(.W(SBITS), .D(NSTG - g + 1)) u_dly (
      .clk   (clk),
      .rst_n (srst_n),
      .din   (stg_codes[g*SBITS +: SBITS]),
      .dout  (al_codes[g*SBITS +: SBITS])
    );
  end

  adcbe_delay #(.W(FBITS), .D(1)) u_fin_dly (
    .clk   (clk),
    .rst_n (srst_n),
    .din   (fin_code),
    .dout  (al_fin)
  );

  adcbe_delay #(.W(1), .D(NSTG + 1)) u_vld_dly (
    .clk   (clk),
    .rst_n (srst_n),
    .din   (in_valid),
    .dout  (vld_al)
  );

  adcbe_combine #(
    .NSTG(NSTG), .SBITS(SBITS), .EBITS(EBITS), .FBITS(FBITS), .OUT_W(OUT_W)
  ) u_comb (
    .codes  (al_codes),
    .fcode  (al_fin),
    .result (sum_res)
  );

  always_comb begin
    out_valid_d = vld_al;
    out_code_d  = out_code_q;
    if (vld_al) out_code_d = sum_res;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      out_valid_q <= 1'b0;
      out_code_q  <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      out_code_q  <= out_code_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_code  = out_code_q;

  // Checking: samples accepted but not yet delivered.
  logic [CNT_W-1:0] inflight_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) inflight_q <= '0;
    else         inflight_q <= inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
  end

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> inflight_q != '0);

  a_r1_bounded_flight: assert property (@(posedge clk) disable iff (!srst_n)
    inflight_q <= CNT_W'(LAT));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!srst_n)
    vld_al |=> out_valid);

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !vld_al |=> (!out_valid && $stable(out_code)));

endmodule

// File: tb/test_pipe_adc_backend.sv
module test_pipe_adc_backend;

  localparam int TL = 48;
  localparam int MS = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] stg_codes;
  logic [3:0]  fin_code;
  logic        out_valid;
  logic [11:0] out_code;

  always #4 clk = ~clk;

  pipe_adc_backend i_pipe_adc_backend (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .stg_codes (stg_codes),
    .fin_code  (fin_code),
    .out_valid (out_valid),
    .out_code  (out_code)
  );

  int n_chk = 0;
  int n_err = 0;
  int last_code = 0;

  logic [2:0] tl_c [4][TL];
  logic [3:0] tl_f [TL];
  logic       tl_v [TL];
  logic       ex_v [TL];
  int         ex_c [TL];

  int s_start [MS];
  int s_code  [MS][5];
  int nsamp = 0;

  function automatic int model(int c1, int c2, int c3, int c4, int f);
    int v;
    v = c1 * 1024 + c2 * 256 + c3 * 64 + c4 * 16 + f - 2720;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic check(string tag, int cyc, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s cycle %0d %s actual=%0d expected=%0d", tag, cyc, what, act, exp);
    end
  endtask

  task automatic add(int st, int c1, int c2, int c3, int c4, int f);
    s_start[nsamp] = st;
    s_code[nsamp][0] = c1; s_code[nsamp][1] = c2; s_code[nsamp][2] = c3;
    s_code[nsamp][3] = c4; s_code[nsamp][4] = f;
    nsamp++;
  endtask

  // Build the timeline (noise in unused slots, R8) and run it cycle by cycle.
  task automatic run(string tag, int ncyc);
    for (int c = 0; c < TL; c++) begin
      for (int k = 0; k < 4; k++) tl_c[k][c] = 3'(c * 3 + k * 5 + 1);
      tl_f[c] = 4'(c * 7 + 2);
      tl_v[c] = 1'b0;
      ex_v[c] = 1'b0;
      ex_c[c] = 0;
    end
    for (int s = 0; s < nsamp; s++) begin
      tl_v[s_start[s]] = 1'b1;
      for (int k = 0; k < 4; k++) tl_c[k][s_start[s] + k] = 3'(s_code[s][k]);
      tl_f[s_start[s] + 4] = 4'(s_code[s][4]);
      ex_v[s_start[s] + 6] = 1'b1;
      ex_c[s_start[s] + 6] = model(s_code[s][0], s_code[s][1], s_code[s][2],
                                   s_code[s][3], s_code[s][4]);
    end
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (ex_v[c]) begin
        check({tag, " R2"}, c, int'(out_valid), 1, "out_valid");
        check(tag, c, int'(out_code), ex_c[c], "out_code");
        last_code = ex_c[c];
      end else begin
        check("R7", c, int'(out_valid), 0, "idle out_valid");
        check("R7", c, int'(out_code), last_code, "held out_code");
      end
      in_valid  = tl_v[c];
      stg_codes = {tl_c[3][c], tl_c[2][c], tl_c[1][c], tl_c[0][c]};
      fin_code  = tl_f[c];
    end
    @(negedge clk);
    in_valid = 1'b0;
    nsamp = 0;
  endtask

  task automatic t_reset();
    check("R7", 0, int'(out_valid), 0, "reset out_valid");
    check("R7", 0, int'(out_code), 0, "reset out_code");
  endtask

  task automatic t_single();   // R3 weights, R2 latency
    add(0, 3, 4, 5, 2, 7);     // 1735
    run("R3", 10);
  endtask

  task automatic t_stream();   // R1 back-to-back
    for (int i = 0; i < 8; i++)
      add(i, 2 + (i % 4), 2 + ((i + 1) % 4), 2 + ((i + 2) % 4), 2 + ((i + 3) % 4), (i * 5) % 16);
    run("R1", 16);
  endtask

  task automatic t_overlap();  // R4 compensated decision errors
    add(0, 3, 4, 5, 2, 7);     // ideal 1735
    add(1, 4, 0, 5, 2, 7);     // stage 1 high, stage 2 compensates
    add(2, 3, 4, 4, 6, 7);     // stage 3 low, stage 4 compensates
    run("R4", 12);
  endtask

  task automatic t_sat_hi();   // R5
    add(0, 7, 7, 7, 7, 15);    // far above range
    add(1, 6, 5, 5, 5, 0);     // 5104 -> 4095
    add(2, 5, 5, 5, 5, 15);    // exactly 4095
    run("R5", 12);
  endtask

  task automatic t_sat_lo();   // R6
    add(0, 0, 0, 0, 0, 0);     // far below
    add(1, 2, 2, 2, 2, 0);     // exactly 0
    add(2, 1, 5, 5, 5, 15);    // -1 -> 0
    add(3, 2, 2, 2, 2, 1);     // 1
    run("R6", 12);
  endtask

  task automatic t_gaps();     // R7 hold, R8 noise ignored
    add(0, 4, 3, 2, 5, 9);
    add(3, 2, 5, 3, 4, 12);
    add(9, 5, 2, 4, 3, 1);
    run("R8", 18);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    stg_codes = '0;
    fin_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_stream();
    t_overlap();
    t_sat_hi();
    t_sat_lo();
    t_gaps();
    summary();
    $finish;
  end

endmodule